// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. Bytes enter through a write strobe into a small transmit queue whose depth is a parameter. The shape of each frame comes from an 8-bit line setting: character length from 5 to 8 bits, one of five parity choices (none, odd, even, forced one, forced zero), one or two stop bits, and a break control that pulls the line low.

A baud enable tick paces the output, and every bit lasts sixteen ticks. The line setting is captured when a frame begins, so a change affects the following character. Break acts on the line at once, but the serializer keeps running underneath it. Two status outputs show whether the serializer is idle and whether the queue is empty.

Top module: `serial_tx`

## Requirements
- R1: After reset, `tx_o` is 1, `tx_idle_o` is 1 and `fifo_empty_o` is 1.
- R2: A frame is one 0 start bit, then the data bits LSB first, then an optional parity bit, then 1 stop bit(s). Each bit holds for 16 `baud_tick_i` pulses. With no frame in progress and break off, the line is 1.
- R3: `line_cfg_i[1:0]` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused high bits of the byte are not sent.
- R4: `line_cfg_i[5:3]` sets parity. If bit 3 is 0 there is no parity bit. Code 001 gives odd parity and 011 gives even parity, both taken over the sent data bits. Code 101 gives a parity bit fixed at 1, and 111 gives one fixed at 0.
- R5: `line_cfg_i[2]` = 0 sends one stop bit and 1 sends two.
- R6: While `line_cfg_i[6]` is 1, `tx_o` is 0. The frame timing carries on underneath, and bytes queued during break are still consumed.
- R7: `tx_idle_o` is 0 while a frame is being sent. When the serializer is idle and the queue holds a byte, the frame starts on the next clock edge. There is exactly one idle cycle between back-to-back frames.
- R8: The queue holds `DEPTH` bytes (default 4). `fifo_empty_o` is 1 exactly when it holds none. A write accepted into a full queue is dropped, where full is judged on the count held before the edge.
- R9: Length, parity and stop settings are sampled when a frame starts. Changing them mid-frame does not alter that frame.
- R10: `line_cfg_i[7]` has no effect on the line or on the status outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the transmit queue |
| wr_data_i | input | 8 | Byte to queue |
| line_cfg_i | input | 8 | Line setting: [7] ignored, [6] break, [5:3] parity, [2] stop, [1:0] length |
| baud_tick_i | input | 1 | Baud enable, 16 pulses per bit |
| tx_o | output | 1 | Serial line |
| tx_idle_o | output | 1 | 1 when no frame is in progress |
| fifo_empty_o | output | 1 | 1 when the queue is empty |

## Verification
The hardest state to reach is a full queue receiving a write while the serializer is mid-frame, with break or a setting change arriving in the same window. To get there, the stimulus writes bursts longer than the queue depth faster than frames drain. It then toggles break and rewrites the length and parity fields partway through a frame. A behavioural model built on queues predicts the line and both status bits on every clock, so a dropped byte, an early settings capture or a stalled serializer under break shows up as a line mismatch.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W   = 8;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + DATA_W + 1 + MAX_STOP;
  localparam int IDX_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic       spare;
    logic       brk;
    logic [2:0] par;
    logic       stop2;
    logic [1:0] clen;
  } line_cfg_t;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ONE  = 2'b10,
    PAR_ZERO = 2'b11
  } par_kind_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q < CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  assert_full_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH) && push_i && !pop_i) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
  import sertx_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  line_cfg_t          cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [IDX_W-1:0]   nbits_o
);
  int        nd;
  logic      ones, pbit, par_en;
  logic      unused_cfg;

  assign unused_cfg = cfg_i.spare ^ cfg_i.brk;
  assign par_en     = cfg_i.par[0];

  always_comb begin
    nd      = 5 + int'(cfg_i.clen);
    frame_o = '1;
    frame_o[0] = 1'b0;
    ones    = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        frame_o[1+i] = data_i[i];
        ones         = ones ^ data_i[i];
      end
    end
    case (par_kind_e'(cfg_i.par[2:1]))
      PAR_ODD:  pbit = ~ones;
      PAR_EVEN: pbit = ones;
      PAR_ONE:  pbit = 1'b1;
      default:  pbit = 1'b0;
    endcase
    if (par_en) frame_o[1+nd] = pbit;
    nbits_o = IDX_W'(2 + nd + int'(par_en) + int'(cfg_i.stop2));
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   nbits_i,
  output logic               busy_o,
  output logic               tx_bit_o
);
  localparam int TCNT_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic               busy_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   nbits_q, idx_q;
  logic [TCNT_W-1:0]  tcnt_q;
  logic               bit_end, last_bit;

  assign bit_end  = tick_i && (tcnt_q == TCNT_W'(OVS - 1));
  assign last_bit = (idx_q == nbits_q - IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      nbits_q <= '0;
      idx_q   <= '0;
      tcnt_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      frame_q <= frame_i;
      nbits_q <= nbits_i;
      idx_q   <= '0;
      tcnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (bit_end) begin
        tcnt_q <= '0;
        if (last_bit) busy_q <= 1'b0;
        else          idx_q  <= idx_q + IDX_W'(1);
      end else begin
        tcnt_q <= tcnt_q + TCNT_W'(1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign tx_bit_o = busy_q ? frame_q[idx_q] : 1'b1;

  assert_hold_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> ($stable(idx_q) && $stable(tcnt_q)));

  assert_frame_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_end && last_bit) |=> !busy_q);

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (tx_bit_o == 1'b0));
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import sertx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int OVS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] line_cfg_i,
  input  logic       baud_tick_i,
  output logic       tx_o,
  output logic       tx_idle_o,
  output logic       fifo_empty_o
);
  line_cfg_t          cfg;
  logic [DATA_W-1:0]  head;
  logic               empty, busy, start, tx_bit;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   nbits;

  assign cfg   = line_cfg_t'(line_cfg_i);
  assign start = !busy && !empty;

  sertx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .data_i  (wr_data_i),
    .pop_i   (start),
    .data_o  (head),
    .empty_o (empty)
  );

  sertx_frame_build u_build (
    .data_i  (head),
    .cfg_i   (cfg),
    .frame_o (frame),
    .nbits_o (nbits)
  );

  sertx_shifter #(.OVS(OVS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (baud_tick_i),
    .start_i  (start),
    .frame_i  (frame),
    .nbits_i  (nbits),
    .busy_o   (busy),
    .tx_bit_o (tx_bit)
  );

  // break overrides the line only; serializer state is untouched
  assign tx_o         = cfg.brk ? 1'b0 : tx_bit;
  assign tx_idle_o    = !busy;
  assign fifo_empty_o = empty;

  assert_start_has_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_idle_o) |-> $past(!fifo_empty_o));
endmodule

// File: tb/sim_serial_tx.sv
`timescale 1ns/1ps
module sim_serial_tx;
  localparam int DEPTH = 4;
  localparam int OVS   = 16;
  localparam int MAX_CYC = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cfg = 8'h03;
  logic       tick = 1'b0;
  logic       tx, idle, empty;

  int vectors = 0, miscompares = 0, cycles = 0, tick_div = 1, gen_cnt = 0;
  string cur_req = "R1";

  // reference model state
  byte unsigned q[$];
  bit  bits[$];
  bit  m_busy = 0;
  int  m_idx = 0, m_tcnt = 0;

  always #2 clk = ~clk;

  serial_tx #(.DEPTH(DEPTH), .OVS(OVS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .line_cfg_i(cfg), .baud_tick_i(tick), .tx_o(tx), .tx_idle_o(idle),
    .fifo_empty_o(empty)
  );

  function automatic void build(byte unsigned d, logic [7:0] c);
    int nd = 5 + int'(c[1:0]);
    int ones = 0;
    bit p;
    bits.delete();
    bits.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      bits.push_back(d[i]);
      ones += d[i];
    end
    if (c[3]) begin
      case (c[5:4])
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      bits.push_back(p);
    end
    bits.push_back(1'b1);
    if (c[2]) bits.push_back(1'b1);
  endfunction

  task automatic check(string what, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %b exp %b at cycle %0d", cur_req, what, got, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic step();
    bit  exp_tx, do_pop, can_push;
    tick = (gen_cnt % tick_div) == 0;
    gen_cnt++;
    @(negedge clk);
    exp_tx = cfg[6] ? 1'b0 : (m_busy ? bits[m_idx] : 1'b1);
    check("tx_o", tx, exp_tx);
    check("tx_idle_o", idle, !m_busy);
    check("fifo_empty_o", empty, q.size() == 0);
    @(posedge clk);
    can_push = wr_en && (q.size() < DEPTH);
    do_pop   = !m_busy && (q.size() > 0);
    if (do_pop) begin
      build(q.pop_front(), cfg);
      m_busy = 1; m_idx = 0; m_tcnt = 0;
    end else if (m_busy && tick) begin
      if (m_tcnt == OVS - 1) begin
        m_tcnt = 0;
        if (m_idx == bits.size() - 1) m_busy = 0;
        else m_idx++;
      end else m_tcnt++;
    end
    if (can_push) q.push_back(byte'(wr_data));
    cycles++;
    #1;
  endtask

  task automatic put(byte unsigned b);
    wr_en = 1'b1; wr_data = b;
    step();
    wr_en = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((m_busy || q.size() > 0) && n < 20000) begin
      step(); n++;
    end
    step();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(MAX_CYC * 4);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state seen while reset is still low
    check("tx_o reset R1", tx, 1'b1);
    check("tx_idle_o reset R1", idle, 1'b1);
    check("fifo_empty_o reset R1", empty, 1'b1);
    rst_n = 1'b1;
    #1;
    run(5);

    // R2 R3: basic frames, every length code
    cur_req = "R2/R3";
    for (int l = 0; l < 4; l++) begin
      cfg = 8'h00 | 8'(l);
      put(8'hA5); put(8'h3C);
      drain();
    end

    // R4: parity codes at 7-bit length, slower ticks
    cur_req = "R4";
    tick_div = 2;
    foreach (cfg_list[k]) ;
    for (int pm = 0; pm < 8; pm++) begin
      cfg = {2'b00, 3'(pm), 1'b0, 2'b10};
      put(8'h5B); put(8'h16);
      drain();
    end

    // R5: two stop bits with parity and 8 bits
    cur_req = "R5";
    tick_div = 3;
    cfg = 8'b0001_1111;
    put(8'hFF); put(8'h00);
    drain();

    // R8 R7: burst beyond depth, back-to-back frames
    cur_req = "R8/R7";
    tick_div = 1;
    cfg = 8'h03;
    for (int i = 0; i < 8; i++) put(byte'(8'h10 + i));
    run(100);
    put(8'hEE);
    drain();

    // R6: break mid-frame with queued bytes
    cur_req = "R6";
    put(8'h81); put(8'h42); put(8'h24);
    run(60);
    cfg[6] = 1'b1;
    run(500);
    put(8'h99);
    run(200);
    cfg[6] = 1'b0;
    drain();

    // R9: settings changed mid-frame
    cur_req = "R9";
    cfg = 8'h00;
    put(8'h1F); put(8'h0E);
    run(40);
    cfg = 8'b0001_1111;
    run(30);
    cfg = 8'b0010_1001;
    drain();

    // R10: top bit set
    cur_req = "R10";
    cfg = 8'h83;
    put(8'hC3);
    drain();
    cfg = 8'b1011_1110;
    put(8'h6D); put(8'h92);
    drain();

    summary();
    $finish;
  end

  int cfg_list[1];
endmodule